// File: doc/BRIEF.md
# Cipher Accelerator DMA Trigger Sequencer

This block sits next to a 128-bit block-cipher core. It turns the core's block-completion strobe and the bus word accesses to the core's data registers into per-word DMA request pulses. A DMA channel running in repeated single-transfer mode can then move a whole block one 32-bit word at a time. The block also raises a completion interrupt toward the CPU.

When the mode-enable input is high, every completed block starts a sequence. First the output is drained: one request is issued for each result word on the drain line. In the chained modes, the feedback or initial-vector words are then loaded on the feedback line. Last, the next input block is filled on the fill line. Each request is a one-cycle pulse. The next pulse on the same line waits until the matching word access has been seen. Each of the four events has a mask bit and a raw status bit, and the raw status bits are cleared by writing ones.

Top module: `cipher_dma_seq`

## Requirements
- R1: A one-cycle `core_done_i` sets raw status bit 0 on the next edge, whatever the state of `mode_en_i`. `irq_o` is high while raw bit 0 is set and mask bit 0 is clear.
- R2: While `mode_en_i` is low, `dma_trig_o` stays all zero.
- R3: In ECB (`chained_i` low), a completion starts the sequence. Line 0 (`dma_trig_o[0]`) pulses four times, each time paced by a `dout_rd_i` word access. Then line 1 pulses four times, paced by `din_wr_i`. Line 2 never fires. After the fourth fill access no pulse appears until the next completion.
- R4: In chained modes (`chained_i` high), four line-0 pulses are followed by four line-2 pulses paced by `fb_wr_i`, and then by four line-1 pulses.
- R5: Each trigger pulse lasts one cycle, and at most one line pulses at a time. After a pulse, that line stays quiet until its word access is seen. The next pulse then appears on the second rising edge after the access cycle. Accesses on a line with no outstanding request are ignored.
- R6: Raw status bits 1, 2 and 3 record pulses on lines 0, 1 and 2. A masked event still sets its raw bit, but the matching output stays low. A masked line still advances on its word accesses.
- R7: A one in `evt_clr_i[k]` clears raw bit k on the next edge. A set and a clear of the same bit in the same cycle leave the bit set.
- R8: Dropping `mode_en_i` in the middle of a sequence returns the block to waiting and resets the word count. After re-enabling, nothing fires until the next completion, which then starts a full four-word drain.
- R9: During and right after reset, all outputs and all raw status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_en_i | input | 1 | Cipher-mode enable for DMA sequencing |
| chained_i | input | 1 | High for chained modes that need feedback words |
| core_done_i | input | 1 | One-cycle strobe: cipher block complete |
| dout_rd_i | input | 1 | Word read of the data-out register |
| din_wr_i | input | 1 | Word write of the data-in register |
| fb_wr_i | input | 1 | Word write of the feedback/vector register |
| evt_mask_i | input | 4 | Per-event mask (bit 0 completion, bits 1..3 lines 0..2) |
| evt_clr_i | input | 4 | Per-event write-one-to-clear |
| evt_raw_o | output | 4 | Per-event raw status |
| irq_o | output | 1 | Completion interrupt (level) |
| dma_trig_o | output | 3 | DMA request pulses: 0 drain, 1 fill, 2 feedback |

## Verification
Sequences are run in ECB and in chained mode with random response delays from the DMA model. While a request is outstanding, stray accesses are injected on the idle lines. This separates correct pacing from triggers that re-fire or counters that step on the wrong strobe. A directed abort after two drain words shows whether the count is cleared: a kept count would shorten the next drain. Masked-trigger and masked-interrupt runs show whether status recording is kept apart from output gating. A simultaneous set and clear shows which of the two takes priority.

// File: rtl/cdseq_pkg.sv
package cdseq_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FEED  = 2'd2,
    ST_FILL  = 2'd3
  } seq_st_e;

  localparam int NUM_TRIG = 3;
  localparam int NUM_EVT  = NUM_TRIG + 1;
  // line index doubles as its DMA trigger number
  localparam int TRIG_OUT = 0;
  localparam int TRIG_IN  = 1;
  localparam int TRIG_FB  = 2;
  localparam int EV_DONE  = 0;
endpackage

// File: rtl/cdseq_word_cnt.sv
module cdseq_word_cnt #(
  parameter int WORDS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic last_o
);
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (step_i && cnt_q == LAST) cnt_q <= '0;
    else if (step_i)                cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

  p_cnt_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  p_cnt_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && last_o) |=> cnt_q == '0);
endmodule

// File: rtl/cdseq_trig_gen.sv
module cdseq_trig_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_i,
  input  logic kill_i,
  output logic pulse_o,
  output logic ack_ok_o
);
  logic pend_q, pulse_q, issue;

  assign issue    = req_i & ~pend_q & ~kill_i;
  assign ack_ok_o = ack_i & pend_q & ~kill_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= issue;
      if (kill_i)        pend_q <= 1'b0;
      else if (issue)    pend_q <= 1'b1;
      else if (ack_i)    pend_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;

  p_single_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  p_pend_with_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> pulse_q);
  p_ack_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_ok_o |=> (!pend_q && !pulse_q));
endmodule

// File: rtl/cdseq_evt_status.sv
module cdseq_evt_status #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | set_i;
  end

  assign stat_o = stat_q;

  p_set_sticks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));
  p_clear_works_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((stat_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/cipher_dma_seq.sv
module cipher_dma_seq
  import cdseq_pkg::*;
#(
  parameter int WORDS_PER_BLK = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_en_i,
  input  logic                chained_i,
  input  logic                core_done_i,
  input  logic                dout_rd_i,
  input  logic                din_wr_i,
  input  logic                fb_wr_i,
  input  logic [NUM_EVT-1:0]  evt_mask_i,
  input  logic [NUM_EVT-1:0]  evt_clr_i,
  output logic [NUM_EVT-1:0]  evt_raw_o,
  output logic                irq_o,
  output logic [NUM_TRIG-1:0] dma_trig_o
);
  seq_st_e st_q, st_d;
  logic [NUM_TRIG-1:0] line_req, line_ack, line_ok, line_pulse;
  logic kill, word_ack, cnt_last, phase_end;

  assign kill     = ~mode_en_i;
  assign line_ack = {fb_wr_i, din_wr_i, dout_rd_i};
  assign word_ack = |line_ok;
  assign phase_end = word_ack & cnt_last;

  always_comb begin
    line_req = '0;
    if (mode_en_i) begin
      unique case (st_q)
        ST_DRAIN: line_req[TRIG_OUT] = 1'b1;
        ST_FEED:  line_req[TRIG_FB]  = 1'b1;
        ST_FILL:  line_req[TRIG_IN]  = 1'b1;
        default:  line_req = '0;
      endcase
    end
  end

  always_comb begin
    st_d = st_q;
    if (kill) st_d = ST_WAIT;
    else begin
      unique case (st_q)
        ST_WAIT:  if (core_done_i) st_d = ST_DRAIN;
        ST_DRAIN: if (phase_end)   st_d = chained_i ? ST_FEED : ST_FILL;
        ST_FEED:  if (phase_end)   st_d = ST_FILL;
        ST_FILL:  if (phase_end)   st_d = ST_WAIT;
        default:                   st_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_WAIT;
    else         st_q <= st_d;
  end

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_line
    cdseq_trig_gen u_trig (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (line_req[g]),
      .ack_i    (line_ack[g]),
      .kill_i   (kill),
      .pulse_o  (line_pulse[g]),
      .ack_ok_o (line_ok[g])
    );
  end

  cdseq_word_cnt #(.WORDS(WORDS_PER_BLK)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (kill | (st_q == ST_WAIT)),
    .step_i (word_ack),
    .last_o (cnt_last)
  );

  cdseq_evt_status #(.N(NUM_EVT)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({line_pulse, core_done_i}),
    .clr_i  (evt_clr_i),
    .stat_o (evt_raw_o)
  );

  assign dma_trig_o = line_pulse & ~evt_mask_i[NUM_EVT-1:1];
  assign irq_o      = evt_raw_o[EV_DONE] & ~evt_mask_i[EV_DONE];

  p_trig_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> dma_trig_o == '0);
  p_one_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(line_pulse));
  p_done_status_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_done_i |=> evt_raw_o[EV_DONE]);
  p_kill_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> st_q == ST_WAIT);
  p_ecb_skip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_en_i && st_q == ST_DRAIN && phase_end && !chained_i) |=> st_q == ST_FILL);
  p_chain_feed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_en_i && st_q == ST_DRAIN && phase_end && chained_i) |=> st_q == ST_FEED);
endmodule

// File: tb/cipher_dma_seq_bench.sv
module cipher_dma_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_en = 1'b0, chained = 1'b0, core_done = 1'b0;
  logic       dout_rd = 1'b0, din_wr = 1'b0, fb_wr = 1'b0;
  logic [3:0] evt_mask = '0, evt_clr = '0;
  logic [3:0] evt_raw;
  logic       irq;
  logic [2:0] dma_trig;

  int nchk = 0, nerr = 0, dbl_err = 0;
  int trig_seen [3] = '{0, 0, 0};
  logic [2:0] prev_trig = '0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cipher_dma_seq u_cipher_dma_seq (
    .clk_i(clk), .rst_ni(rst_n), .mode_en_i(mode_en), .chained_i(chained),
    .core_done_i(core_done), .dout_rd_i(dout_rd), .din_wr_i(din_wr), .fb_wr_i(fb_wr),
    .evt_mask_i(evt_mask), .evt_clr_i(evt_clr), .evt_raw_o(evt_raw),
    .irq_o(irq), .dma_trig_o(dma_trig)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 3; k++) begin
        if (dma_trig[k]) trig_seen[k]++;
        if (dma_trig[k] && prev_trig[k]) dbl_err++;
      end
      prev_trig = dma_trig;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] line_bit(input int line);
    return 3'(1 << line);
  endfunction

  task automatic drive_acc(input int line, input logic v);
    case (line)
      0: dout_rd = v;
      1: din_wr  = v;
      default: fb_wr = v;
    endcase
  endtask

  task automatic idle_quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(dma_trig == 3'b000, req, dma_trig, 0);
    end
  endtask

  task automatic pulse_done();
    core_done = 1'b1;
    @(negedge clk);
    core_done = 1'b0;
  endtask

  task automatic clear_all();
    evt_clr = 4'hF;
    @(negedge clk);
    evt_clr = 4'h0;
  endtask

  // wait for one request on 'line', then answer it after a random delay
  task automatic serve(input int line, input string req);
    int t = 0;
    int d;
    int stray;
    while (dma_trig == 3'b000 && t < 60) begin
      @(negedge clk);
      t++;
    end
    chk(dma_trig == line_bit(line), req, dma_trig, line_bit(line));
    d = $urandom_range(1, 4);
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      dout_rd = 1'b0; din_wr = 1'b0; fb_wr = 1'b0;
      chk(dma_trig == 3'b000, "R5", dma_trig, 0);
      if ($urandom_range(0, 1) == 1) begin
        stray = (line + 1 + $urandom_range(0, 1)) % 3;
        drive_acc(stray, 1'b1);
      end
    end
    @(negedge clk);
    dout_rd = 1'b0; din_wr = 1'b0; fb_wr = 1'b0;
    chk(dma_trig == 3'b000, "R5", dma_trig, 0);
    drive_acc(line, 1'b1);
    @(negedge clk);
    drive_acc(line, 1'b0);
  endtask

  function automatic int exp_pulses(input bit ch, input int line);
    if (line == 2) return ch ? 4 : 0;
    return 4;
  endfunction

  task automatic run_block(input bit ch);
    int base [3];
    string tag;
    tag = ch ? "R4" : "R3";
    for (int k = 0; k < 3; k++) base[k] = trig_seen[k];
    chained = ch;
    pulse_done();
    for (int w = 0; w < 4; w++) serve(0, tag);
    if (ch) for (int w = 0; w < 4; w++) serve(2, tag);
    for (int w = 0; w < 4; w++) serve(1, tag);
    idle_quiet(8, "R3");
    for (int k = 0; k < 3; k++)
      chk(trig_seen[k] - base[k] == exp_pulses(ch, k), tag, trig_seen[k] - base[k],
          exp_pulses(ch, k));
    chk(dbl_err == 0, "R5", dbl_err, 0);
  endtask

  initial begin
    int base0;
    void'($urandom(32'd1357));
    #1;
    // R9 reset state
    chk(dma_trig == 3'b000 && !irq && evt_raw == 4'h0, "R9", {evt_raw, irq, dma_trig}, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dma_trig == 3'b000 && !irq && evt_raw == 4'h0, "R9", {evt_raw, irq, dma_trig}, 0);

    // R1/R2: completion with enable low
    pulse_done();
    chk(evt_raw == 4'b0001, "R1", evt_raw, 1);
    chk(irq == 1'b1, "R1", irq, 1);
    idle_quiet(10, "R2");
    clear_all();
    chk(evt_raw == 4'h0 && !irq, "R7", evt_raw, 0);

    // R3: ECB directed
    mode_en = 1'b1;
    @(negedge clk);
    run_block(1'b0);
    chk(evt_raw == 4'b0111, "R6", evt_raw, 4'b0111);
    clear_all();

    // R4: chained directed
    run_block(1'b1);
    chk(evt_raw == 4'b1111, "R6", evt_raw, 4'b1111);
    clear_all();

    // R8: abort mid-drain
    chained = 1'b0;
    pulse_done();
    serve(0, "R8");
    serve(0, "R8");
    mode_en = 1'b0;
    idle_quiet(15, "R8");
    mode_en = 1'b1;
    idle_quiet(10, "R8");
    run_block(1'b0);
    clear_all();

    // R6: masked drain line still advances
    evt_mask = 4'b0010;
    base0 = trig_seen[0];
    pulse_done();
    repeat (3) @(negedge clk);
    chk(evt_raw[1] == 1'b1, "R6", evt_raw[1], 1);
    for (int w = 0; w < 4; w++) begin
      dout_rd = 1'b1;
      @(negedge clk);
      dout_rd = 1'b0;
      if (w < 3) idle_quiet(3, "R6");
    end
    for (int w = 0; w < 4; w++) serve(1, "R6");
    chk(trig_seen[0] == base0, "R6", trig_seen[0], base0);
    idle_quiet(6, "R6");
    evt_mask = 4'h0;
    clear_all();

    // R6/R1/R7: interrupt mask and set-vs-clear priority
    mode_en = 1'b0;
    evt_mask = 4'b0001;
    pulse_done();
    chk(evt_raw[0] == 1'b1 && irq == 1'b0, "R6", {evt_raw[0], irq}, 2);
    evt_mask = 4'b0000;
    #0;
    chk(irq == 1'b1, "R1", irq, 1);
    core_done = 1'b1;
    evt_clr = 4'b0001;
    @(negedge clk);
    core_done = 1'b0;
    evt_clr = 4'b0000;
    chk(evt_raw[0] == 1'b1, "R7", evt_raw[0], 1);
    clear_all();
    chk(evt_raw[0] == 1'b0 && irq == 1'b0, "R7", evt_raw[0], 0);

    // random blocks
    mode_en = 1'b1;
    for (int b = 0; b < 12; b++) begin
      run_block(1'($urandom_range(0, 1)));
      clear_all();
      repeat ($urandom_range(0, 5)) @(negedge clk);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule